// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block is the software-visible state store of an interrupt distributor. A processor reaches it over a simple 32-bit register bus with per-byte write enables. For every implemented interrupt line it keeps the following state:
- an enable bit;
- a pending bit;
- a group bit;
- an 8-bit priority;
- an 8-bit CPU target mask.

It also holds a global control word with one enable per group. Two read-only words describe the bank: a type word and an identification word.

Enable and pending state each have two addresses. One address sets bits where a one is written, and the other clears them. Both addresses read back the live state, so software never needs a read-modify-write to change a single line. Lines beyond the implemented count read as zero and cannot be set. Software can therefore write all ones and read the result back to find the highest implemented line.

The state is presented as flat vectors to a downstream arbiter. That arbiter, the CPU interface and any security banking live elsewhere.

Top module: `irqd_regbank`

## Requirements
- R1: After reset, every enable, pending, group, priority and target bit is 0, both group enables are 0 and `rd_valid` is 0.
- R2: A write to a set-enable word (0x100 + 4·w, covering lines 32w..32w+31) sets each line's enable bit whose data bit is 1. Data bits that are 0 change nothing.
- R3: A write to a clear-enable word (0x180 + 4·w) clears each enable bit whose data bit is 1. Both the set-enable and clear-enable addresses read the current enable bits.
- R4: Pending state behaves the same way at 0x200 + 4·w (set) and 0x280 + 4·w (clear), with one exception. Set writes have no effect on lines 0–15, while clear writes act on every line.
- R5: Enable, pending, group, priority and target bits of unimplemented lines read as 0 after any write, whether the line is at or above `NUM_LINES` or in a word beyond the last implemented word.
- R6: The type word at 0x004 reads (number of implemented 32-line words − 1) in bits 4:0 and 0 elsewhere. Writes to it are ignored.
- R7: The identification word at 0xFE8 reads `ARCH_REV` in bits 7:4 and 0 elsewhere.
- R8: The control word at 0x000 stores bit 0 (group 0 enable, output `grp0_en`) and bit 1 (group 1 enable, output `grp1_en`). Its other bits read 0.
- R9: Group words at 0x080 + 4·w are plain read/write, one bit per line. Only bytes with their byte enable set are written.
- R10: The priority of line i is the byte at address 0x400 + i, which is byte i mod 4 of word (i div 4). Each byte is written only when its own byte enable is set.
- R11: The CPU target mask of line i is byte i mod 4 of the word at 0x800 + 4·(i div 4).
- R12: Reads of undefined or misaligned addresses (addr[1:0] ≠ 0) return 0, and writes to them change no state.
- R13: On set and clear words, bits in bytes whose byte enable is 0 are not affected.
- R14: Read data appears on `rd_data` with `rd_valid` high exactly one cycle after the read request. `rd_data` holds its value when no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the word |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Registered read data |
| grp0_en | output | 1 | Group 0 global enable |
| grp1_en | output | 1 | Group 1 global enable |
| line_enable | output | NUM_LINES | Per-line enable |
| line_pending | output | NUM_LINES | Per-line pending |
| line_group | output | NUM_LINES | Per-line group |
| line_prio | output | 8·NUM_LINES | Per-line priority, line i at bits 8i+7:8i |
| line_target | output | 8·NUM_LINES | Per-line CPU mask, line i at bits 8i+7:8i |

## Verification
The assertions watch several properties on every cycle:
- a set write never lowers a bit, and a clear write never raises one;
- a set write leaves the software-generated pending lines unchanged;
- the byte arrays are stable when they are not written;
- a write to an undefined address leaves all state intact;
- read data is stable between reads.

Only the bench's scenarios can show the rest. That covers the exact readback values, the type and identification contents, the edge of the implemented range, byte-enable masking, byte placement within priority and target words, and the effect of a mid-run reset.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_TYPE, RG_ID, RG_GROUP,
    RG_SETEN, RG_CLREN, RG_SETPEND, RG_CLRPEND, RG_PRIO, RG_TARGET
  } region_e;

  localparam logic [11:0] ADDR_ID = 12'hFE8;

  // expand byte enables into a bit mask
  function automatic logic [31:0] be_to_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{be[k]}};
    return m;
  endfunction

  // replace the masked bits of a word
  function automatic logic [31:0] merge_word(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [31:0] mask);
    return (old_w & ~mask) | (new_w & mask);
  endfunction

  // count of 32-line words needed for n lines
  function automatic int words_for(input int n);
    return (n + 31) / 32;
  endfunction

endpackage

// File: rtl/irqd_decode.sv
module irqd_decode
  import irqd_pkg::*;
#(
  parameter int NUM_WORDS  = 3,
  parameter int BYTE_WORDS = 20
) (
  input  logic [11:0] addr,
  output region_e     region,
  output logic [7:0]  idx
);
  logic bit_ok;
  logic byte_ok;

  assign bit_ok  = int'(addr[6:2]) < NUM_WORDS;
  assign byte_ok = int'(addr[9:2]) < BYTE_WORDS;

  always_comb begin
    region = RG_NONE;
    idx    = 8'd0;
    if (addr[1:0] != 2'b00) begin
      region = RG_NONE;
    end else if (addr == ADDR_ID) begin
      region = RG_ID;
    end else if (addr[11:10] == 2'b01) begin
      if (byte_ok) begin
        region = RG_PRIO;
        idx    = addr[9:2];
      end
    end else if (addr[11:10] == 2'b10) begin
      if (byte_ok) begin
        region = RG_TARGET;
        idx    = addr[9:2];
      end
    end else if (addr[11:10] == 2'b00) begin
      unique case (addr[9:7])
        3'd0: begin
          if (addr[6:0] == 7'h00) region = RG_CTRL;
          else if (addr[6:0] == 7'h04) region = RG_TYPE;
        end
        3'd1: if (bit_ok) region = RG_GROUP;
        3'd2: if (bit_ok) region = RG_SETEN;
        3'd3: if (bit_ok) region = RG_CLREN;
        3'd4: if (bit_ok) region = RG_SETPEND;
        3'd5: if (bit_ok) region = RG_CLRPEND;
        default: region = RG_NONE;
      endcase
      idx = {3'b000, addr[6:2]};
    end
  end
endmodule

// File: rtl/irqd_sc_bits.sv
module irqd_sc_bits #(
  parameter int NUM_LINES  = 80,
  parameter int LOCK_LINES = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_we,
  input  logic                 clr_we,
  input  logic [4:0]           widx,
  input  logic [31:0]          wmask,
  output logic [NUM_LINES-1:0] bits_q
);
  logic [NUM_LINES-1:0] set_hit;
  logic [NUM_LINES-1:0] clr_hit;
  logic [NUM_LINES-1:0] bits_d;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      set_hit[i] = set_we && ((i / 32) == int'(widx)) && wmask[i % 32] && (i >= LOCK_LINES);
      clr_hit[i] = clr_we && ((i / 32) == int'(widx)) && wmask[i % 32];
    end
    bits_d = (bits_q | set_hit) & ~clr_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  AST_SET_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((bits_q & $past(bits_q)) == $past(bits_q))); // R2
  AST_CLR_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((bits_q & ~$past(bits_q)) == '0)); // R3

  if (LOCK_LINES > 0) begin : g_lock
    AST_LOCKED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> (bits_q[LOCK_LINES-1:0] == $past(bits_q[LOCK_LINES-1:0]))); // R4
  end
endmodule

// File: rtl/irqd_byte_regs.sv
module irqd_byte_regs #(
  parameter int NUM_LINES = 80
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [7:0]             widx,
  input  logic [3:0]             be,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  output logic [NUM_LINES*8-1:0] bytes_flat
);
  logic [7:0]           mem [NUM_LINES];
  logic [NUM_LINES-1:0] byte_hit;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_byte
    assign byte_hit[i] = we && ((i / 4) == int'(widx)) && be[i % 4];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           mem[i] <= 8'h00;
      else if (byte_hit[i]) mem[i] <= wdata[8*(i%4) +: 8];
    end
    assign bytes_flat[8*i +: 8] = mem[i];
  end

  always_comb begin
    rdata = 32'h0;
    for (int i = 0; i < NUM_LINES; i++)
      if ((i / 4) == int'(widx)) rdata[8*(i%4) +: 8] = mem[i];
  end

  AST_BYTES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(bytes_flat)); // R10
endmodule

// File: rtl/irqd_regbank.sv
module irqd_regbank
  import irqd_pkg::*;
#(
  parameter int NUM_LINES = 80,
  parameter int ARCH_REV  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_valid,
  input  logic                   bus_write,
  input  logic [11:0]            bus_addr,
  input  logic [3:0]             bus_be,
  input  logic [31:0]            bus_wdata,
  output logic                   rd_valid,
  output logic [31:0]            rd_data,
  output logic                   grp0_en,
  output logic                   grp1_en,
  output logic [NUM_LINES-1:0]   line_enable,
  output logic [NUM_LINES-1:0]   line_pending,
  output logic [NUM_LINES-1:0]   line_group,
  output logic [NUM_LINES*8-1:0] line_prio,
  output logic [NUM_LINES*8-1:0] line_target
);
  localparam int NUM_WORDS  = words_for(NUM_LINES);
  localparam int BYTE_WORDS = (NUM_LINES + 3) / 4;
  localparam int PADW       = NUM_WORDS * 32;
  localparam int SGI_LINES  = 16;

  region_e     region;
  logic [7:0]  idx;
  logic        wr_evt;
  logic        rd_evt;
  logic [31:0] wmask;
  logic [31:0] prio_rdata;
  logic [31:0] tgt_rdata;
  logic [1:0]  ctrl_q;
  logic [NUM_LINES-1:0] grp_q;
  logic [NUM_LINES-1:0] grp_d;
  logic [PADW-1:0] en_pad, pend_pad, grp_pad;
  logic [31:0] en_words   [NUM_WORDS];
  logic [31:0] pend_words [NUM_WORDS];
  logic [31:0] grp_words  [NUM_WORDS];
  logic [31:0] rd_mux;

  assign wr_evt = bus_valid && bus_write;
  assign rd_evt = bus_valid && !bus_write;
  assign wmask  = be_to_mask(bus_be);

  irqd_decode #(.NUM_WORDS(NUM_WORDS), .BYTE_WORDS(BYTE_WORDS)) u_dec (
    .addr(bus_addr), .region(region), .idx(idx));

  irqd_sc_bits #(.NUM_LINES(NUM_LINES), .LOCK_LINES(0)) u_enable (
    .clk(clk), .rst_n(rst_n),
    .set_we(wr_evt && region == RG_SETEN),
    .clr_we(wr_evt && region == RG_CLREN),
    .widx(idx[4:0]), .wmask(wmask & bus_wdata), .bits_q(line_enable));

  irqd_sc_bits #(.NUM_LINES(NUM_LINES), .LOCK_LINES(SGI_LINES)) u_pending (
    .clk(clk), .rst_n(rst_n),
    .set_we(wr_evt && region == RG_SETPEND),
    .clr_we(wr_evt && region == RG_CLRPEND),
    .widx(idx[4:0]), .wmask(wmask & bus_wdata), .bits_q(line_pending));

  irqd_byte_regs #(.NUM_LINES(NUM_LINES)) u_prio (
    .clk(clk), .rst_n(rst_n), .we(wr_evt && region == RG_PRIO),
    .widx(idx), .be(bus_be), .wdata(bus_wdata),
    .rdata(prio_rdata), .bytes_flat(line_prio));

  irqd_byte_regs #(.NUM_LINES(NUM_LINES)) u_target (
    .clk(clk), .rst_n(rst_n), .we(wr_evt && region == RG_TARGET),
    .widx(idx), .be(bus_be), .wdata(bus_wdata),
    .rdata(tgt_rdata), .bytes_flat(line_target));

  // group bits: plain read/write under byte enables
  always_comb begin
    grp_d = grp_q;
    if (wr_evt && region == RG_GROUP)
      for (int i = 0; i < NUM_LINES; i++)
        if (((i / 32) == int'(idx[4:0])) && wmask[i % 32])
          grp_d[i] = bus_wdata[i % 32];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q  <= '0;
      ctrl_q <= 2'b00;
    end else begin
      grp_q <= grp_d;
      if (wr_evt && region == RG_CTRL)
        ctrl_q <= merge_word({30'h0, ctrl_q}, bus_wdata, wmask)[1:0];
    end
  end

  assign line_group = grp_q;
  assign grp0_en    = ctrl_q[0];
  assign grp1_en    = ctrl_q[1];

  assign en_pad   = PADW'(line_enable);
  assign pend_pad = PADW'(line_pending);
  assign grp_pad  = PADW'(grp_q);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_words
    assign en_words[w]   = en_pad[w*32 +: 32];
    assign pend_words[w] = pend_pad[w*32 +: 32];
    assign grp_words[w]  = grp_pad[w*32 +: 32];
  end

  always_comb begin
    rd_mux = 32'h0;
    unique case (region)
      RG_CTRL: rd_mux = {30'h0, ctrl_q};
      RG_TYPE: rd_mux = {27'h0, 5'(NUM_WORDS - 1)};
      RG_ID:   rd_mux = {24'h0, 4'(ARCH_REV), 4'h0};
      RG_PRIO:   rd_mux = prio_rdata;
      RG_TARGET: rd_mux = tgt_rdata;
      RG_GROUP, RG_SETEN, RG_CLREN, RG_SETPEND, RG_CLRPEND: begin
        for (int w = 0; w < NUM_WORDS; w++)
          if (w == int'(idx[4:0])) begin
            if (region == RG_GROUP)
              rd_mux = grp_words[w];
            else if (region == RG_SETEN || region == RG_CLREN)
              rd_mux = en_words[w];
            else
              rd_mux = pend_words[w];
          end
      end
      default: rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 32'h0;
    end else begin
      rd_valid <= rd_evt;
      if (rd_evt) rd_data <= rd_mux;
    end
  end

  AST_UNDEF_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && region == RG_NONE) |=> ($stable(line_enable) && $stable(line_pending)
      && $stable(line_group) && $stable(line_prio) && $stable(line_target)
      && $stable(grp0_en) && $stable(grp1_en))); // R12
  AST_RD_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> $stable(rd_data)); // R14
endmodule

// File: tb/irqd_regbank_bench.sv
`timescale 1ns/1ps
module irqd_regbank_bench;
  localparam int NL = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic rd_valid, grp0_en, grp1_en;
  logic [31:0] rd_data;
  logic [NL-1:0] line_enable, line_pending, line_group;
  logic [NL*8-1:0] line_prio, line_target;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irqd_regbank #(.NUM_LINES(NL), .ARCH_REV(2)) u_irqd_regbank (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .grp0_en(grp0_en), .grp1_en(grp1_en),
    .line_enable(line_enable), .line_pending(line_pending), .line_group(line_group),
    .line_prio(line_prio), .line_target(line_target));

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h004, 4'hF, 32'h0,        32'h00000002, 8'd6},  // R6 three words
    '{1'b0, 12'hFE8, 4'hF, 32'h0,        32'h00000020, 8'd7},  // R7 revision 2
    '{1'b0, 12'h100, 4'hF, 32'h0,        32'h00000000, 8'd1},  // R1
    '{1'b1, 12'h100, 4'hF, 32'hFFFFFFFF, 32'h0,        8'd2},
    '{1'b0, 12'h100, 4'hF, 32'h0,        32'hFFFFFFFF, 8'd2},  // R2
    '{1'b1, 12'h180, 4'hF, 32'h0000FF00, 32'h0,        8'd3},
    '{1'b0, 12'h180, 4'hF, 32'h0,        32'hFFFF00FF, 8'd3},  // R3
    '{1'b1, 12'h100, 4'hF, 32'h00000000, 32'h0,        8'd2},
    '{1'b0, 12'h100, 4'hF, 32'h0,        32'hFFFF00FF, 8'd2},  // R2 zeros inert
    '{1'b1, 12'h108, 4'hF, 32'hFFFFFFFF, 32'h0,        8'd5},
    '{1'b0, 12'h108, 4'hF, 32'h0,        32'h0000FFFF, 8'd5},  // R5 lines 80..95
    '{1'b1, 12'h10C, 4'hF, 32'hFFFFFFFF, 32'h0,        8'd5},
    '{1'b0, 12'h10C, 4'hF, 32'h0,        32'h00000000, 8'd5},  // R5 word 3
    '{1'b1, 12'h200, 4'hF, 32'hFFFFFFFF, 32'h0,        8'd4},
    '{1'b0, 12'h200, 4'hF, 32'h0,        32'hFFFF0000, 8'd4},  // R4 lines 0..15 locked
    '{1'b1, 12'h204, 4'h3, 32'hFFFFFFFF, 32'h0,        8'd13},
    '{1'b0, 12'h284, 4'hF, 32'h0,        32'h0000FFFF, 8'd13}, // R13
    '{1'b1, 12'h280, 4'hF, 32'h00030000, 32'h0,        8'd4},
    '{1'b0, 12'h200, 4'hF, 32'h0,        32'hFFFC0000, 8'd4},  // R4 clear
    '{1'b1, 12'h080, 4'h5, 32'h12345678, 32'h0,        8'd9},
    '{1'b0, 12'h080, 4'hF, 32'h0,        32'h00340078, 8'd9},  // R9
    '{1'b1, 12'h400, 4'h2, 32'hAABBCCDD, 32'h0,        8'd10},
    '{1'b0, 12'h400, 4'hF, 32'h0,        32'h0000CC00, 8'd10}, // R10
    '{1'b1, 12'h44C, 4'hF, 32'h11223344, 32'h0,        8'd10},
    '{1'b0, 12'h44C, 4'hF, 32'h0,        32'h11223344, 8'd10}, // R10 lines 76..79
    '{1'b1, 12'h450, 4'hF, 32'hFFFFFFFF, 32'h0,        8'd5},
    '{1'b0, 12'h450, 4'hF, 32'h0,        32'h00000000, 8'd5},  // R5 prio past end
    '{1'b1, 12'h814, 4'h8, 32'h80000000, 32'h0,        8'd11},
    '{1'b0, 12'h814, 4'hF, 32'h0,        32'h80000000, 8'd11}, // R11 line 23
    '{1'b1, 12'h000, 4'hF, 32'hFFFFFFFF, 32'h0,        8'd8},
    '{1'b0, 12'h000, 4'hF, 32'h0,        32'h00000003, 8'd8},  // R8
    '{1'b1, 12'h300, 4'hF, 32'hFFFFFFFF, 32'h0,        8'd12},
    '{1'b0, 12'h300, 4'hF, 32'h0,        32'h00000000, 8'd12}, // R12
    '{1'b1, 12'h004, 4'hF, 32'hFFFFFFFF, 32'h0,        8'd6},
    '{1'b0, 12'h004, 4'hF, 32'h0,        32'h00000002, 8'd6},  // R6 read-only
    '{1'b1, 12'h106, 4'hF, 32'hFFFFFFFF, 32'h0,        8'd12},
    '{1'b0, 12'h104, 4'hF, 32'h0,        32'h00000000, 8'd12}  // R12 misaligned
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [11:0] a, input logic [3:0] be,
                        input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R14 watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 enable", 32'(line_enable[31:0] | line_pending[31:0] | line_group[31:0]), 32'h0);
    check("R1 rd_valid", {31'h0, rd_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      access(VECS[v].wr, VECS[v].addr, VECS[v].be, VECS[v].data);
      if (!VECS[v].wr)
        check($sformatf("R%0d vec%0d", VECS[v].req, v), rd_data, VECS[v].exp);
    end

    // state seen at the ports
    check("R3 line_enable[15:0]", 32'(line_enable[15:0]), 32'h00FF);
    check("R2 line_enable[79:64]", 32'(line_enable[79:64]), 32'hFFFF);
    check("R4 line_pending[31:0]", line_pending[31:0], 32'hFFFC0000);
    check("R13 line_pending[63:32]", line_pending[63:32], 32'h0000FFFF);
    check("R9 line_group[31:0]", line_group[31:0], 32'h00340078);
    check("R10 prio line1", 32'(line_prio[8*1 +: 8]), 32'hCC);
    check("R10 prio line76", 32'(line_prio[8*76 +: 8]), 32'h44);
    check("R11 target line23", 32'(line_target[8*23 +: 8]), 32'h80);
    check("R8 group enables", {30'h0, grp1_en, grp0_en}, 32'h3);

    // R14 read latency and hold
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 12'hFE8; bus_be = 4'hF;
    @(negedge clk);
    bus_valid = 1'b0;
    check("R14 rd_valid high", {31'h0, rd_valid}, 32'h1);
    check("R14 rd_data", rd_data, 32'h20);
    @(negedge clk);
    check("R14 rd_valid low", {31'h0, rd_valid}, 32'h0);
    check("R14 rd_data held", rd_data, 32'h20);

    // R1 mid-run reset
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 enable after reset", 32'(line_enable[31:0]), 32'h0);
    check("R1 pending after reset", line_pending[31:0], 32'h0);
    check("R1 ctrl after reset", {30'h0, grp1_en, grp0_en}, 32'h0);
    check("R1 target after reset", 32'(line_target[8*23 +: 8]), 32'h0);
    access(1'b0, 12'h44C, 4'hF, 32'h0);
    check("R1 prio readback", rd_data, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule